// File: doc/BRIEF.md
# Modem Status Change Detector

This block holds the modem status byte of a 16550-style serial port. Four modem input lines (clear-to-send, data-set-ready, ring indicator, carrier detect) pass through a synchroniser. They are then held as current levels in the upper nibble of the status byte. Every change of a level is recorded as a sticky flag in the lower nibble. Reading the byte hands the host both nibbles and then clears the flags. An interrupt request is raised while the host has enabled it and at least one flag is set.

The ring indicator flag differs from the other three. It records only the end of a ring, meaning the line falling from 1 to 0. The other flags record a change in either direction. In loopback mode the upper nibble shown to the host comes from the modem control outputs instead of the pins, and the lower nibble reads as zero. The pins are still tracked in the background.

Top module: `modem_status_reg`

## Requirements
- R1: After reset `status` reads 8'hB0 (carrier detect, data-set-ready and clear-to-send set, ring clear, all flags clear) and `irq` is low.
- R2: The status bit positions are bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring, bit 7 carrier detect. `line_in` carries them at index 0 CTS, 1 DSR, 2 RI, 3 DCD.
- R3: A change of CTS, DSR or DCD in either direction sets flag bit 0, 1 or 3 respectively. A flag, once set, stays set through further changes until it is cleared by a read.
- R4: Flag bit 2 is set only when the synchronised ring level falls from 1 to 0. A rising ring level leaves it clear.
- R5: In the cycle `rd_stb` is high (and loopback is off), `status` shows the current flags. From the next edge the flags are clear, except for changes detected at that same edge.
- R6: `irq` is high exactly when `irq_en` is high and at least one flag is set. It drops in the cycle after a read clears the flags.
- R7: With `loop_en` high, `status` bit 4 = `mctl[1]`, bit 5 = `mctl[0]`, bit 6 = `mctl[2]`, bit 7 = `mctl[3]`, and bits 3:0 read zero.
- R8: A read while `loop_en` is high leaves the flags untouched. Pin changes during loopback are recorded and appear once loopback ends.
- R9: A pin change first shows at `status` after exactly SYNC_STAGES+1 rising clock edges, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 4 | Raw modem lines: 0 CTS, 1 DSR, 2 RI, 3 DCD (active-high levels) |
| mctl | input | 4 | Modem control bits: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2 |
| loop_en | input | 1 | Loopback mode select |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | One-cycle host read strobe of the status byte |
| status | output | 8 | Status byte as seen by the host |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A lost or spurious flag shows as a wrong lower nibble within SYNC_STAGES+1 edges of the pin change. It also shows as `irq` going high or staying low when `irq_en` is set. A stale level register shows as a wrong upper nibble at the same edge, and produces an extra or a missing flag on the next change. A read that fails to clear, or clears too much, shows one cycle after the strobe. Both the nibble and `irq` are compared against a behavioural model every cycle, so each of these errors is caught in the cycle it first appears.

// File: rtl/msr_pkg.sv
package msr_pkg;
   localparam int unsigned NLINES  = 4;
   localparam int unsigned IDX_CTS = 0;
   localparam int unsigned IDX_DSR = 1;
   localparam int unsigned IDX_RI  = 2;
   localparam int unsigned IDX_DCD = 3;

   // Pin-index mask of lines whose flag fires on any change
   localparam logic [NLINES-1:0] ANY_EDGE_MASK = 4'b1011;

   // Level seen on the lines while held in reset: DCD, DSR, CTS high, RI low
   localparam logic [NLINES-1:0] IDLE_LEVELS = 4'b1011;

   // Modem control bit positions
   localparam int unsigned MC_DTR  = 0;
   localparam int unsigned MC_RTS  = 1;
   localparam int unsigned MC_OUT1 = 2;
   localparam int unsigned MC_OUT2 = 3;

   // Loopback view: modem control bits rerouted into line order
   function automatic logic [NLINES-1:0] loop_levels(input logic [3:0] mc);
      logic [NLINES-1:0] l;
      l[IDX_CTS] = mc[MC_RTS];
      l[IDX_DSR] = mc[MC_DTR];
      l[IDX_RI]  = mc[MC_OUT1];
      l[IDX_DCD] = mc[MC_OUT2];
      return l;
   endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int unsigned         WIDTH  = 4,
   parameter int unsigned         STAGES = 2,
   parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("msr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/msr_track.sv
module msr_track
   import msr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] lvl_in,
   input  logic              clr,
   output logic [NLINES-1:0] lvl_q,
   output logic [NLINES-1:0] flag_q
);
   logic [NLINES-1:0] hit;

   for (genvar i = 0; i < NLINES; i++) begin : g_hit
      if (ANY_EDGE_MASK[i]) begin : g_any
         assign hit[i] = lvl_in[i] ^ lvl_q[i];
      end else begin : g_fall
         assign hit[i] = lvl_q[i] & ~lvl_in[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= IDLE_LEVELS;
         flag_q <= '0;
      end else begin
         lvl_q  <= lvl_in;
         flag_q <= (clr ? '0 : flag_q) | hit;
      end
   end

   // R3: a flag stays set unless a clear was requested
   a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R3: a change of the CTS level is always flagged
   a_r3_cts_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[IDX_CTS] != $past(lvl_q[IDX_CTS])) |-> flag_q[IDX_CTS]);

   // R4: a rising ring level never raises the ring flag
   a_r4_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_q[IDX_RI]) |-> !$rose(flag_q[IDX_RI]));

   // R5: after a clear only a fresh CTS change can hold the CTS flag
   a_r5_clear_cts: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flag_q[IDX_CTS] == (lvl_q[IDX_CTS] ^ $past(lvl_q[IDX_CTS]))));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
   import msr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] line_in,
   input  logic [3:0] mctl,
   input  logic       loop_en,
   input  logic       irq_en,
   input  logic       rd_stb,
   output logic [7:0] status,
   output logic       irq
);
   logic [NLINES-1:0] line_s;
   logic [NLINES-1:0] lvl_q;
   logic [NLINES-1:0] flag_q;
   logic              clr;

   msr_sync #(
      .WIDTH  (NLINES),
      .STAGES (SYNC_STAGES),
      .RST_VAL(IDLE_LEVELS)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (line_in),
      .q    (line_s)
   );

   assign clr = rd_stb & ~loop_en;

   msr_track u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_in(line_s),
      .clr   (clr),
      .lvl_q (lvl_q),
      .flag_q(flag_q)
   );

   always_comb begin
      if (loop_en) status = {loop_levels(mctl), 4'h0};
      else         status = {lvl_q, flag_q};
   end

   assign irq = irq_en & (|flag_q);

   // R6: a request always has an enable and a recorded flag behind it
   a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && (flag_q != '0)));

   // R8: reads during loopback leave the flags in place
   a_r8_loop_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && loop_en) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] line_in = 4'b1011;
   logic [3:0] mctl = 4'h0;
   logic       loop_en = 1'b0;
   logic       irq_en = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] status;
   logic       irq;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   // behavioural model state
   logic [3:0] m_pipe [SYNC];
   logic [3:0] m_lvl;
   logic [3:0] m_flag;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_status_reg #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .mctl(mctl),
      .loop_en(loop_en), .irq_en(irq_en), .rd_stb(rd_stb),
      .status(status), .irq(irq)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_status();
      if (loop_en) return {mctl[3], mctl[2], mctl[0], mctl[1], 4'h0};
      return {m_lvl, m_flag};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < SYNC; i++) m_pipe[i] = 4'b1011;
      m_lvl  = 4'b1011;
      m_flag = 4'h0;
   endtask

   // One clock: model follows the edge, then compare at the falling edge
   task automatic step();
      logic [3:0] nl;
      logic [3:0] ev;
      @(posedge clk);
      nl = m_pipe[SYNC-1];
      for (int i = SYNC-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = line_in;
      ev = (nl ^ m_lvl) & 4'b1011;
      if (m_lvl[2] && !nl[2]) ev[2] = 1'b1;
      m_flag = ((rd_stb && !loop_en) ? 4'h0 : m_flag) | ev;
      m_lvl = nl;
      @(negedge clk);
      cycles++;
      check8("R5 model status", status, model_status());
      check8("R6 model irq", {7'b0, irq}, {7'b0, irq_en && (m_flag != 0)});
      if (cycles > WATCHDOG) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_read();
      rd_stb = 1'b1;
      step();
      rd_stb = 1'b0;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1 reset status", status, 8'hB0);
      check8("R1 reset irq", {7'b0, irq}, 8'h00);

      irq_en = 1'b1;
      // R9/R2/R3: CTS falls
      line_in = 4'b1010;
      steps(SYNC);
      check8("R9 not yet visible", status, 8'hB0);
      step();
      check8("R2 R3 cts fall", status, 8'hA1);
      check8("R6 irq on flag", {7'b0, irq}, 8'h01);
      // R3: rise back, flag sticky
      line_in = 4'b1011;
      steps(SYNC + 1);
      check8("R3 sticky flag", status, 8'hB1);
      // R5: read shows flags then clears
      rd_stb = 1'b1;
      #1 check8("R5 read value", status, 8'hB1);
      step();
      rd_stb = 1'b0;
      check8("R5 cleared", status, 8'hB0);
      check8("R6 irq drops", {7'b0, irq}, 8'h00);
      // R4: ring rise then fall
      line_in = 4'b1111;
      steps(SYNC + 1);
      check8("R4 ring rise quiet", status, 8'hF0);
      line_in = 4'b1011;
      steps(SYNC + 1);
      check8("R4 ring trailing edge", status, 8'hB4);
      do_read();
      // R2: DCD and DSR low together
      line_in = 4'b0001;
      steps(SYNC + 1);
      check8("R2 R3 dcd dsr fall", status, 8'h1A);
      do_read();
      line_in = 4'b1011;
      steps(SYNC + 1);
      do_read();
      check8("R5 clear after restore", status, 8'hB0);
      // R7: loopback mapping
      loop_en = 1'b1;
      mctl = 4'b0101;
      step();
      check8("R7 loop dtr out1", status, 8'h60);
      mctl = 4'b1010;
      step();
      check8("R7 loop rts out2", status, 8'h90);
      // R8: pin change and read during loopback
      line_in = 4'b1001;
      steps(SYNC + 1);
      do_read();
      loop_en = 1'b0;
      step();
      check8("R8 flag kept through loop", status, 8'h92);
      irq_en = 1'b0;
      step();
      check8("R6 irq disabled", {7'b0, irq}, 8'h00);
      irq_en = 1'b1;
      // R5: change landing on the clearing edge survives
      line_in = 4'b1000;
      steps(SYNC);
      do_read();
      check8("R5 same-edge change kept", status, 8'h81);
      // mixed pattern sweep against the model
      for (int k = 0; k < 40; k++) begin
         line_in = 4'((k * 7 + 3) % 16);
         rd_stb = (k % 5 == 2);
         loop_en = (k % 11 == 6);
         mctl = 4'(k);
         step();
      end
      rd_stb = 1'b0;
      loop_en = 1'b0;
      steps(4);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule